// File: doc/BRIEF.md
# Multi-Mode Linear-to-Physical Address Walker

This block turns a 64-bit linear address into a 32-bit physical address. It does so by reading page-table entries from memory, one read at a time. The caller pulses a start strobe together with the address and a snapshot of the translation controls: paging on/off, the table base, the large-page enable, the extended-table enable, the long-mode flag and an address-line mask. The block captures that snapshot and then chooses one of four paths:

- **Pass-through**: paging is off, and no table is read.
- **Two-level classic walk**: 4-byte entries, with optional 4 MB pages.
- **Three-level extended walk**: 8-byte entries, with 2 MB pages.
- **Four-level long-mode walk**: the three-level walk plus a top level and a canonical-address check.

Only the low 32 bits of each entry are used. Bit 0 of each entry is its present flag and bit 7 is its large-page flag. Every entry address is ANDed with the captured address-line mask before it is read.

The walk ends with a one-cycle `done` pulse. That pulse carries either the physical address or a fault. While `busy` is high, any new start is ignored.

Top module: `page_walker`

## Requirements
- R1: When paging is off, the result is the low 32 bits of the linear address, with no fault and no memory read. This holds whatever the other controls are.
- R2: In the classic walk, the directory entry is read at (base with bits 11:0 cleared) plus linear[31:22]×4. The table entry is then read at (directory entry with bits 11:0 cleared) plus linear[21:12]×4. The result is table-entry bits 31:12 joined with linear[11:0].
- R3: In the classic walk, a directory entry maps a 4 MB page only when its bit 7 and the large-page enable are both set. The result is then entry bits 31:22 joined with linear[21:0], after one read. Otherwise the entry points to a second-level table.
- R4: In the extended walk without long mode, the first read is at (base with bits 4:0 cleared) plus linear[31:30]×8. The directory index is linear[29:21] and the table index is linear[20:12], each scaled by 8. Each next-level base is the previous entry with bits 11:0 cleared.
- R5: In long mode (the extended enable and the long flag both set), linear[63:47] must be all zeros or all ones. Otherwise the walk faults with no read. A valid walk first reads (base with bits 11:0 cleared) plus linear[47:39]×8, and then reads the next level at index linear[38:30]×8.
- R6: In the extended and long-mode walks, a directory entry with bit 7 set maps a 2 MB page, whether or not the large-page enable is set. The result is entry bits 31:21 joined with linear[20:0].
- R7: Every entry address is ANDed with the address-line mask captured at start.
- R8: An entry read with bit 0 clear ends the walk at once with `fault` high and `physAddr` zero.
- R9: A memory request holds `memReqValid` and a stable `memReqAddr` until `memReqReady`. Only one read is outstanding at a time.
- R10: `busy` is high from the cycle after start until `done`. `done` is a one-cycle pulse, and `busy` is low after it. A start seen while busy has no effect on the walk in progress.
- R11: When the extended enable is clear, the long flag is ignored and the classic walk is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start pulse, taken when not busy |
| linAddr | input | 64 | Linear address to translate |
| pagingOn | input | 1 | Paging enable |
| tableBase | input | 32 | Top-level table base |
| pseOn | input | 1 | Classic 4 MB page enable |
| paeOn | input | 1 | Extended (8-byte entry) tables enable |
| longOn | input | 1 | Long-mode active |
| a20Mask | input | 32 | Mask ANDed into every entry address |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 32 | Read address |
| memRspValid | input | 1 | Read data valid (one cycle) |
| memRspData | input | 32 | Read data (low half of entry) |
| done | output | 1 | Walk finished pulse |
| fault | output | 1 | Walk faulted (valid with done) |
| physAddr | output | 32 | Physical address (valid with done) |

## Verification
The bench uses the default parameters, so the present flag is bit 0 and the large-page flag is bit 7. With these defaults, every entry format can be built from hand-written table images:

- the classic 4 KB and 4 MB pages;
- the extended 4 KB and 2 MB pages;
- the full four-level path.

A memory model that stalls each request by one cycle exercises request holding. Missing table entries read as zero, so a wrong entry address or a wrong mask shows up as a fault or a wrong result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int LIN_W    = 64;
  localparam int PA_W     = 32;
  localparam int ENT_W    = 32;
  localparam int OFF_W    = 12;
  localparam int CANON_LO = 47;

  localparam logic [PA_W-1:0] MASK_4K  = PA_W'(32'h0000_0FFF);
  localparam logic [PA_W-1:0] MASK_2M  = PA_W'(32'h001F_FFFF);
  localparam logic [PA_W-1:0] MASK_4M  = PA_W'(32'h003F_FFFF);
  localparam logic [PA_W-1:0] MASK_PDP = PA_W'(32'h0000_001F);

  typedef enum logic [1:0] {LVL_PT, LVL_PD, LVL_PDPT, LVL_TOP} level_e;
  typedef enum logic [1:0] {MODE_BARE, MODE_CLASSIC, MODE_EXT, MODE_LONG} mode_e;

  typedef struct packed {
    logic capture;
    logic loadEntry;
    logic finBare;
    logic finLarge;
    logic finSmall;
  } dpStrobe_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int PRESENT_BIT = 0,
  parameter int LARGE_BIT   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  level_e           level,
  input  logic [LIN_W-1:0] linIn,
  input  logic             pgIn,
  input  logic             paeIn,
  input  logic             pseIn,
  input  logic             lmIn,
  input  logic [PA_W-1:0]  baseIn,
  input  logic [PA_W-1:0]  a20In,
  input  logic [ENT_W-1:0] rspData,
  output mode_e            mode,
  output logic             canonical,
  output logic             rspPresent,
  output logic             rspLarge,
  output logic [PA_W-1:0]  reqAddr,
  output logic [PA_W-1:0]  physAddr
);
  logic [LIN_W-1:0] linQ;
  logic [PA_W-1:0]  baseQ, a20Q, rawAddr, offMask;
  logic [ENT_W-1:0] entQ;
  logic             pgQ, paeQ, pseQ, lmQ;
  logic [PA_W-1:0]  entFrame, baseFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linQ <= '0; baseQ <= '0; a20Q <= '0; entQ <= '0;
      pgQ <= 1'b0; paeQ <= 1'b0; pseQ <= 1'b0; lmQ <= 1'b0;
      physAddr <= '0;
    end else begin
      if (strobe.capture) begin
        linQ <= linIn; baseQ <= baseIn; a20Q <= a20In;
        pgQ <= pgIn; paeQ <= paeIn; pseQ <= pseIn; lmQ <= lmIn;
        physAddr <= '0;
      end
      if (strobe.loadEntry) entQ <= rspData;
      if (strobe.finBare) physAddr <= linQ[PA_W-1:0];
      if (strobe.finLarge || strobe.finSmall)
        physAddr <= (rspData[PA_W-1:0] & ~offMask) | (linQ[PA_W-1:0] & offMask);
    end
  end

  always_comb begin
    if (!pgQ)             mode = MODE_BARE;
    else if (paeQ && lmQ) mode = MODE_LONG;
    else if (paeQ)        mode = MODE_EXT;
    else                  mode = MODE_CLASSIC;
  end

  assign canonical = (&linQ[LIN_W-1:CANON_LO]) | ~(|linQ[LIN_W-1:CANON_LO]);

  assign rspPresent = rspData[PRESENT_BIT];
  assign rspLarge   = rspData[LARGE_BIT] & ((mode != MODE_CLASSIC) | pseQ);

  always_comb begin
    if (strobe.finSmall)         offMask = MASK_4K;
    else if (mode == MODE_CLASSIC) offMask = MASK_4M;
    else                         offMask = MASK_2M;
  end

  assign entFrame  = entQ[PA_W-1:0] & ~MASK_4K;
  assign baseFrame = baseQ & ~MASK_4K;

  always_comb begin
    unique case (level)
      LVL_TOP:  rawAddr = baseFrame | PA_W'({linQ[47:39], 3'b000});
      LVL_PDPT: rawAddr = (mode == MODE_LONG)
                          ? (entFrame | PA_W'({linQ[38:30], 3'b000}))
                          : ((baseQ & ~MASK_PDP) | PA_W'({linQ[31:30], 3'b000}));
      LVL_PD:   rawAddr = (mode == MODE_CLASSIC)
                          ? (baseFrame | PA_W'({linQ[31:22], 2'b00}))
                          : (entFrame  | PA_W'({linQ[29:21], 3'b000}));
      default:  rawAddr = (mode == MODE_CLASSIC)
                          ? (entFrame | PA_W'({linQ[21:12], 2'b00}))
                          : (entFrame | PA_W'({linQ[20:12], 3'b000}));
    endcase
  end

  assign reqAddr = rawAddr & a20Q;

  AST_RESULT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> physAddr == '0);  // R8
  AST_BARE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finBare |=> physAddr == $past(linQ[PA_W-1:0]));  // R1
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  input  mode_e     mode,
  input  logic      canonical,
  input  logic      rspPresent,
  input  logic      rspLarge,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output dpStrobe_t strobe,
  output level_e    level,
  output logic      busy,
  output logic      memReqValid,
  output logic      done,
  output logic      fault
);
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_REQ, ST_WAIT, ST_DONE} state_e;

  state_e stateQ, stateD;
  level_e levelD;
  logic   faultD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      level  <= LVL_PD;
      fault  <= 1'b0;
    end else begin
      stateQ <= stateD;
      level  <= levelD;
      fault  <= faultD;
    end
  end

  always_comb begin
    stateD = stateQ;
    levelD = level;
    faultD = fault;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (startValid) begin
        strobe.capture = 1'b1;
        faultD = 1'b0;
        stateD = ST_CHECK;
      end
      ST_CHECK: begin
        unique case (mode)
          MODE_BARE: begin
            strobe.finBare = 1'b1;
            stateD = ST_DONE;
          end
          MODE_LONG: begin
            if (!canonical) begin
              faultD = 1'b1;
              stateD = ST_DONE;
            end else begin
              levelD = LVL_TOP;
              stateD = ST_REQ;
            end
          end
          MODE_EXT: begin
            levelD = LVL_PDPT;
            stateD = ST_REQ;
          end
          default: begin
            levelD = LVL_PD;
            stateD = ST_REQ;
          end
        endcase
      end
      ST_REQ: if (memReqReady) stateD = ST_WAIT;
      ST_WAIT: if (memRspValid) begin
        if (!rspPresent) begin
          faultD = 1'b1;
          stateD = ST_DONE;
        end else begin
          unique case (level)
            LVL_TOP: begin
              strobe.loadEntry = 1'b1;
              levelD = LVL_PDPT;
              stateD = ST_REQ;
            end
            LVL_PDPT: begin
              strobe.loadEntry = 1'b1;
              levelD = LVL_PD;
              stateD = ST_REQ;
            end
            LVL_PD: begin
              if (rspLarge) begin
                strobe.finLarge = 1'b1;
                stateD = ST_DONE;
              end else begin
                strobe.loadEntry = 1'b1;
                levelD = LVL_PT;
                stateD = ST_REQ;
              end
            end
            default: begin
              strobe.finSmall = 1'b1;
              stateD = ST_DONE;
            end
          endcase
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy        = (stateQ != ST_IDLE);
  assign memReqValid = (stateQ == ST_REQ);
  assign done        = (stateQ == ST_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R10
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);  // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);  // R9
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int PRESENT_BIT = 0,
  parameter int LARGE_BIT   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [LIN_W-1:0] linAddr,
  input  logic             pagingOn,
  input  logic [PA_W-1:0]  tableBase,
  input  logic             pseOn,
  input  logic             paeOn,
  input  logic             longOn,
  input  logic [PA_W-1:0]  a20Mask,
  output logic             busy,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [ENT_W-1:0] memRspData,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  physAddr
);
  dpStrobe_t strobe;
  level_e    level;
  mode_e     mode;
  logic      canonical, rspPresent, rspLarge;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .mode(mode), .canonical(canonical), .rspPresent(rspPresent), .rspLarge(rspLarge),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .strobe(strobe), .level(level), .busy(busy), .memReqValid(memReqValid),
    .done(done), .fault(fault)
  );

  ptw_datapath #(.PRESENT_BIT(PRESENT_BIT), .LARGE_BIT(LARGE_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .level(level),
    .linIn(linAddr), .pgIn(pagingOn), .paeIn(paeOn), .pseIn(pseOn), .lmIn(longOn),
    .baseIn(tableBase), .a20In(a20Mask), .rspData(memRspData),
    .mode(mode), .canonical(canonical), .rspPresent(rspPresent), .rspLarge(rspLarge),
    .reqAddr(memReqAddr), .physAddr(physAddr)
  );

  AST_BARE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> mode != MODE_BARE);  // R1
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));  // R9
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> physAddr == '0);  // R8
  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && mode != MODE_CLASSIC |-> memReqAddr[2:0] == 3'b000);  // R4
  AST_CLASSIC_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[1:0] == 2'b00);  // R2
endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [63:0] linAddr = '0;
  logic        pagingOn = 1'b0, pseOn = 1'b0, paeOn = 1'b0, longOn = 1'b0;
  logic [31:0] tableBase = '0, a20Mask = '1;
  logic        busy, memReqValid, memReqReady, memRspValid, done, fault;
  logic [31:0] memReqAddr, memRspData, physAddr;

  int total = 0, fails = 0, readCount = 0, holdErr = 0;
  logic [31:0] memModel [logic [31:0]];

  always #10 clk = ~clk;  // 50 MHz

  page_walker dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .linAddr(linAddr),
    .pagingOn(pagingOn), .tableBase(tableBase), .pseOn(pseOn), .paeOn(paeOn),
    .longOn(longOn), .a20Mask(a20Mask), .busy(busy), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .done(done), .fault(fault), .physAddr(physAddr)
  );

  typedef struct packed {
    logic [63:0] lin;
    logic [31:0] base;
    logic [31:0] a20;
    logic        pg, pae, pse, lm;
    logic        expFault;
    logic [31:0] expPa;
    logic [2:0]  expReads;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0040_3ABC, 32'h0001_0000, 32'hFFFF_FFFF, 1'b1,1'b0,1'b0,1'b0, 1'b0, 32'h1234_5ABC, 3'd2},
    '{64'h0000_0000_00C1_2345, 32'h0001_0000, 32'hFFFF_FFFF, 1'b1,1'b0,1'b1,1'b0, 1'b0, 32'h0801_2345, 3'd1},
    '{64'h0000_0000_00C1_2345, 32'h0001_0000, 32'hFFFF_FFFF, 1'b1,1'b0,1'b0,1'b0, 1'b0, 32'h0ABC_D345, 3'd2},
    '{64'h0000_0000_0080_0000, 32'h0001_0000, 32'hFFFF_FFFF, 1'b1,1'b0,1'b0,1'b0, 1'b1, 32'h0000_0000, 3'd1},
    '{64'h0000_0000_0040_5000, 32'h0001_0000, 32'hFFFF_FFFF, 1'b1,1'b0,1'b0,1'b0, 1'b1, 32'h0000_0000, 3'd2},
    '{64'h0000_0000_0040_3ABC, 32'h0011_0000, 32'hFFEF_FFFF, 1'b1,1'b0,1'b0,1'b0, 1'b0, 32'h1234_5ABC, 3'd2},
    '{64'h0000_0000_4060_1ABC, 32'h0003_0020, 32'hFFFF_FFFF, 1'b1,1'b1,1'b0,1'b0, 1'b0, 32'h0777_7ABC, 3'd3},
    '{64'h0000_0000_4080_0123, 32'h0003_0020, 32'hFFFF_FFFF, 1'b1,1'b1,1'b0,1'b0, 1'b0, 32'h0660_0123, 3'd2},
    '{64'hFFFF_8000_0020_3ABC, 32'h0006_0000, 32'hFFFF_FFFF, 1'b1,1'b1,1'b0,1'b1, 1'b0, 32'h0ACE_0ABC, 3'd4},
    '{64'h0000_8000_0000_0000, 32'h0006_0000, 32'hFFFF_FFFF, 1'b1,1'b1,1'b0,1'b1, 1'b1, 32'h0000_0000, 3'd0},
    '{64'h0000_0000_0000_0000, 32'h0006_0000, 32'hFFFF_FFFF, 1'b1,1'b1,1'b0,1'b1, 1'b1, 32'h0000_0000, 3'd1},
    '{64'hDEAD_BEEF_1234_5678, 32'h0006_0000, 32'hFFFF_FFFF, 1'b0,1'b1,1'b1,1'b1, 1'b0, 32'h1234_5678, 3'd0},
    '{64'hFFFF_0000_0040_3ABC, 32'h0001_0000, 32'hFFFF_FFFF, 1'b1,1'b0,1'b0,1'b1, 1'b0, 32'h1234_5ABC, 3'd2}
  };
  // Row tags: classic 4K, 4M, bit7 without enable, directory missing, table missing,
  // mask, extended 4K, extended 2M, long 4K, non-canonical, top missing, bare, long ignored
  string tags [NV] = '{"R2", "R3", "R3", "R8", "R8", "R7", "R4", "R6", "R5", "R5", "R8", "R1", "R11"};

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Memory model: one stall cycle per request, response the cycle after acceptance
  initial begin
    logic        stalled;
    logic [31:0] heldAddr, acceptAddr;
    stalled = 1'b0; heldAddr = '0; acceptAddr = '0;
    memReqReady = 1'b0; memRspValid = 1'b0; memRspData = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (memReqReady) begin
        memReqReady = 1'b0;
        memRspValid = 1'b1;
        memRspData = memModel.exists(acceptAddr) ? memModel[acceptAddr] : 32'h0;
        readCount++;
        stalled = 1'b0;
      end else if (memReqValid) begin
        if (!stalled) begin
          stalled = 1'b1;
          heldAddr = memReqAddr;
        end else begin
          if (memReqAddr !== heldAddr) holdErr++;
          memReqReady = 1'b1;
          acceptAddr = memReqAddr;
        end
      end
    end
  end

  task automatic applyVec(input vec_t v);
    linAddr = v.lin; tableBase = v.base; a20Mask = v.a20;
    pagingOn = v.pg; paeOn = v.pae; pseOn = v.pse; longOn = v.lm;
  endtask

  task automatic waitDone(input string tag, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) check(tag, "done timeout", 64'd0, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    bit ok;
    memModel[32'h0001_0004] = 32'h0002_0001;
    memModel[32'h0002_000C] = 32'h1234_5001;
    memModel[32'h0001_000C] = 32'h0800_0081;
    memModel[32'h0800_0048] = 32'h0ABC_D001;
    memModel[32'h0003_0028] = 32'h0004_0001;
    memModel[32'h0004_0018] = 32'h0005_0001;
    memModel[32'h0005_0008] = 32'h0777_7001;
    memModel[32'h0004_0020] = 32'h0665_5081;
    memModel[32'h0006_0800] = 32'h0007_0001;
    memModel[32'h0007_0000] = 32'h0008_0001;
    memModel[32'h0008_0008] = 32'h0009_0001;
    memModel[32'h0009_0018] = 32'h0ACE_0001;

    repeat (3) @(negedge clk);
    // Reset state (R10, R9)
    check("R10", "busy in reset", 64'(busy), 64'd0);
    check("R10", "done in reset", 64'(done), 64'd0);
    check("R9", "req in reset", 64'(memReqValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      applyVec(VECS[k]);
      readCount = 0;
      startValid = 1'b1;
      @(negedge clk);
      startValid = 1'b0;
      waitDone(tags[k], ok);
      if (ok) begin
        check(tags[k], $sformatf("vec%0d fault", k), 64'(fault), 64'(VECS[k].expFault));
        check(tags[k], $sformatf("vec%0d physAddr", k), 64'(physAddr), 64'(VECS[k].expPa));
        check(tags[k], $sformatf("vec%0d reads", k), 64'(readCount), 64'(VECS[k].expReads));
      end
      @(negedge clk);
      check("R10", $sformatf("vec%0d done pulse width", k), 64'(done), 64'd0);
      check("R10", $sformatf("vec%0d idle after", k), 64'(busy), 64'd0);
    end

    // Start while busy is ignored (R10)
    applyVec(VECS[0]);
    readCount = 0;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    @(negedge clk);
    check("R10", "busy during walk", 64'(busy), 64'd1);
    linAddr = 64'h0000_0000_0000_0777; pagingOn = 1'b0;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    waitDone("R10", ok);
    if (ok) begin
      check("R10", "busy start ignored pa", 64'(physAddr), 64'h1234_5ABC);
      check("R10", "busy start ignored reads", 64'(readCount), 64'd2);
    end
    repeat (3) @(negedge clk);
    check("R10", "no second walk", 64'(busy), 64'd0);

    // Request held stable while stalled (R9)
    check("R9", "request address changes while stalled", 64'(holdErr), 64'd0);

    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule